// File: doc/BRIEF.md
# Two-wire serial EEPROM slave (1 KiB)

This block is a two-wire bus slave that looks like a 1 KiB byte-addressed EEPROM to a bus master. A fast system clock samples the clock and data lines. The block finds start and stop conditions, matches the device address byte, and takes care of byte writes, page writes of up to 16 bytes, current-address reads, random reads and sequential reads. The data line is open-drain: the block never drives it high. It only pulls it low through an output-enable.

Write data goes into a one-page buffer and reaches the byte array only when the stop condition arrives. A timed busy window then models the self-timed nonvolatile write. During that window the slave ignores the bus, so a master can poll for completion by sending the device address until it is acknowledged. While the write-protect input is high, the upper half of the array cannot be changed.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device address byte is acknowledged only when its bits 7:4 are 1010 and its bit 3 equals `a2_i`. In any other case the slave leaves SDA released through that byte and its ninth clock.
- R2: Bit 0 of the device address byte selects the direction: 1 is read and 0 is write. In a write, bits 2:1 become address bits 9:8. In a read, the internal address counter is used unchanged.
- R3: A byte write (device address, word address, one data byte, stop) acknowledges every byte. After the write window ends, the byte reads back at that address.
- R4: In a page write, each data byte goes to the slot given by the counter's low 4 bits, which wrap inside the 16-byte page. A byte beyond the sixteenth replaces the earlier byte in its slot.
- R5: Buffered write data is committed only by a stop. A start condition that arrives before the stop discards the data, and no write window follows.
- R6: A stop that ends a write carrying at least one data byte opens a busy window of `WR_CYCLES` clocks. Inside that window no address byte is acknowledged and SDA stays released. After the window the address is acknowledged again.
- R7: When `wp_i` is high at the stop, no byte at an address with bit 9 set is changed. Those data bytes are still acknowledged. Bytes in the lower half are written normally.
- R8: A random read works as follows: a write of the device and word address, then a repeated start, then a read address byte. It returns the byte at that word address.
- R9: A sequential read sends one byte for each master acknowledge. The address increments after every byte and wraps from 0x3FF to 0x000. Transmission ends on a master not-acknowledge.
- R10: The address counter keeps its value between transactions. A current-address read returns the byte that follows the last byte accessed.
- R11: After reset, SDA is released, the slave is idle and no write window is open.
- R12: The acknowledge pulls SDA low during the ninth clock after a byte. The slave changes its SDA drive only while the synchronised SCL is low.
- R13: A stop condition returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| wp_i | input | 1 | Write-protect for the upper half of the array |
| a2_i | input | 1 | Address strap compared against device address bit 3 |

## Verification
The hardest state to reach from the pins is the busy window. It needs a second transaction to start in the short gap after a committing stop. The bench shortens `WR_CYCLES`, launches an address byte straight after the stop and expects a missing acknowledge. It then waits out the window and expects an acknowledge. A second hard case is a repeated start that cuts into a write before its stop. The bench sends a data byte, issues a new start, and then shows at the pins that the slave is not busy and that the old byte is still in place.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} ee_st_t;
  typedef enum logic [1:0] {RK_DEV, RK_WADR, RK_WDAT} ee_rk_t;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_ee_lines.sv
module i2c_ee_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_val,
  output logic start_evt,
  output logic stop_evt
);
  // [0] first sync stage, [1] synchronised value, [2] previous synchronised value
  logic [2:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_hi    = scl_sh[1];
  assign sda_val   = sda_sh[1];
  assign scl_rise  =  scl_sh[1] & ~scl_sh[2];
  assign scl_fall  = ~scl_sh[1] &  scl_sh[2];
  assign start_evt =  scl_sh[1] &  scl_sh[2] & ~sda_sh[1] &  sda_sh[2];
  assign stop_evt  =  scl_sh[1] &  scl_sh[2] &  sda_sh[1] & ~sda_sh[2];
endmodule

// File: rtl/i2c_ee_fsm.sv
module i2c_ee_fsm
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_hi,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       sda_val,
  input  logic                       start_evt,
  input  logic                       stop_evt,
  input  logic                       busy,
  input  logic                       a2_i,
  input  logic [7:0]                 rd_data,
  output logic                       sda_low,
  output logic [ADDR_W-1:0]          rd_addr,
  output logic                       commit,
  output logic [ADDR_W-PAGE_W-1:0]   pg_base,
  output logic [(1<<PAGE_W)*8-1:0]   pg_data,
  output logic [(1<<PAGE_W)-1:0]     pg_valid
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BLK_W  = ADDR_W - 8;

  ee_st_t            st_q, st_d;
  ee_rk_t            rk_q, rk_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic              rnw_q, rnw_d, ack_q, ack_d, mack_q, mack_d;
  logic              low_q, low_d, commit_q, commit_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_N-1:0] valid_q;
  logic              buf_we, buf_clr;
  logic [7:0]        pbuf [PAGE_N];
  logic              dev_hit;

  assign dev_hit = (sh_q[7:4] == DEV_CODE) && (sh_q[3] == a2_i);

  always_comb begin
    st_d = st_q; rk_d = rk_q; bit_d = bit_q; sh_d = sh_q; rnw_d = rnw_q;
    ack_d = ack_q; mack_d = mack_q; low_d = low_q; addr_d = addr_q;
    commit_d = 1'b0; buf_we = 1'b0; buf_clr = 1'b0;
    if (busy) begin
      st_d = ST_IDLE; low_d = 1'b0;
    end else if (start_evt) begin
      st_d = ST_RX; rk_d = RK_DEV; bit_d = '0; low_d = 1'b0; buf_clr = 1'b1;
    end else if (stop_evt) begin
      st_d = ST_IDLE; low_d = 1'b0; commit_d = |valid_q;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_val};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_d = ST_ACK;
            unique case (rk_q)
              RK_DEV: begin
                ack_d = dev_hit; rnw_d = sh_q[0];
                if (dev_hit && !sh_q[0]) addr_d[ADDR_W-1:8] = sh_q[BLK_W:1];
              end
              RK_WADR: begin
                ack_d = 1'b1; addr_d[7:0] = sh_q;
              end
              default: begin
                ack_d = 1'b1; buf_we = 1'b1;
                addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + 1'b1;
              end
            endcase
            low_d = ack_d;
          end
        end
        ST_ACK: if (scl_fall) begin
          low_d = 1'b0; bit_d = '0;
          if (!ack_q) st_d = ST_IDLE;
          else if (rk_q == RK_DEV && rnw_q) begin
            st_d = ST_TX; sh_d = rd_data; low_d = ~rd_data[7];
          end else begin
            st_d = ST_RX;
            rk_d = (rk_q == RK_DEV) ? RK_WADR : RK_WDAT;
          end
        end
        ST_TX: if (scl_fall) begin
          bit_d = bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            st_d = ST_MACK; low_d = 1'b0; addr_d = addr_q + 1'b1;
          end else begin
            sh_d = {sh_q[6:0], 1'b0}; low_d = ~sh_q[6];
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_val;
          else if (scl_fall) begin
            bit_d = '0;
            if (mack_q) begin
              st_d = ST_TX; sh_d = rd_data; low_d = ~rd_data[7];
            end else st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rk_q <= RK_DEV; bit_q <= '0; sh_q <= '0; rnw_q <= 1'b0;
      ack_q <= 1'b0; mack_q <= 1'b0; low_q <= 1'b0; addr_q <= '0; commit_q <= 1'b0;
    end else begin
      st_q <= st_d; rk_q <= rk_d; bit_q <= bit_d; sh_q <= sh_d; rnw_q <= rnw_d;
      ack_q <= ack_d; mack_q <= mack_d; low_q <= low_d; addr_q <= addr_d; commit_q <= commit_d;
    end
  end

  // page buffer: occupancy is reset, contents are not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (buf_clr || commit_q) valid_q <= '0;
    else if (buf_we) valid_q[addr_q[PAGE_W-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[addr_q[PAGE_W-1:0]] <= sh_q;
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_flat
    assign pg_data[g*8 +: 8] = pbuf[g];
  end

  assign sda_low  = low_q;
  assign rd_addr  = addr_q;
  assign commit   = commit_q;
  assign pg_base  = addr_q[ADDR_W-1:PAGE_W];
  assign pg_valid = valid_q;

  // R12: SDA drive moves only while the synchronised clock is low
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(low_q) |-> !scl_hi);
  // R13: a stop leaves the slave idle and the line released
  assert_stop_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st_q == ST_IDLE) && !low_q);
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 600000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] pg_base,
  input  logic [(1<<PAGE_W)*8-1:0] pg_data,
  input  logic [(1<<PAGE_W)-1:0]   pg_valid,
  input  logic                     wp_i,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int MEM_N  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WR_CYCLES);

  logic              busy_q, busy_d, lock_q, lock_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [PAGE_N-1:0] pend_q, pend_d;
  logic [PAGE_W-1:0] slot;
  logic              mem_we;
  logic [7:0]        mem [MEM_N];

  assign slot   = bcnt_q[PAGE_W-1:0];
  assign mem_we = busy_q && (bcnt_q < CNT_W'(PAGE_N)) && pend_q[slot]
                  && !(lock_q && pg_base[ADDR_W-PAGE_W-1]);

  always_comb begin
    busy_d = busy_q; bcnt_d = bcnt_q; pend_d = pend_q; lock_d = lock_q;
    if (commit) begin
      busy_d = 1'b1; bcnt_d = '0; pend_d = pg_valid; lock_d = wp_i;
    end else if (busy_q) begin
      if (bcnt_q == CNT_W'(WR_CYCLES - 1)) busy_d = 1'b0;
      else bcnt_d = bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; bcnt_q <= '0; pend_q <= '0; lock_q <= 1'b0;
    end else begin
      busy_q <= busy_d; bcnt_q <= bcnt_d; pend_q <= pend_d; lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{pg_base, slot}] <= pg_data[{slot, 3'b000} +: 8];
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;

  // R5: the write window opens only in answer to a commit from the protocol side
  assert_busy_from_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit));
  // R6: the window closes only after its full length
  assert_window_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bcnt_q) == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i,
  input  logic a2_i
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  logic scl_hi, scl_rise, scl_fall, sda_val, start_evt, stop_evt;
  logic busy, commit, sda_low;
  logic [7:0]               rd_data;
  logic [ADDR_W-1:0]        rd_addr;
  logic [ADDR_W-PAGE_W-1:0] pg_base;
  logic [PAGE_N*8-1:0]      pg_data;
  logic [PAGE_N-1:0]        pg_valid;

  i2c_ee_lines u_lines (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_val(sda_val),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_ee_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_val(sda_val), .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy),
    .a2_i(a2_i), .rd_data(rd_data), .sda_low(sda_low), .rd_addr(rd_addr),
    .commit(commit), .pg_base(pg_base), .pg_data(pg_data), .pg_valid(pg_valid)
  );

  i2c_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_sn), .commit(commit), .pg_base(pg_base), .pg_data(pg_data),
    .pg_valid(pg_valid), .wp_i(wp_i), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  assign sda_oe = sda_low;

  // R6: while the write window runs, the line is never pulled
  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |-> !sda_oe);
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int   WR = 1500;
  localparam int   Q  = 8;
  localparam logic A2 = 1'b1;
  // {word address, data, write-protect}
  localparam logic [18:0] VEC [6] = '{
    {10'h005, 8'hA5, 1'b0}, {10'h1FF, 8'h3C, 1'b0}, {10'h200, 8'h11, 1'b0},
    {10'h200, 8'h99, 1'b1}, {10'h3FF, 8'h7E, 1'b0}, {10'h1FF, 8'h55, 1'b1}
  };

  logic clk = 1'b0, rst_n, m_scl, m_sda, wp, sda_oe, sda_bus, done;
  int   checks = 0, errors = 0;
  logic [7:0] model [1024];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wp_i(wp), .a2_i(A2)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bit_out(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask
  task automatic bit_in(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_bus; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic start_c();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic stop_c();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask
  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(s);
    ack = ~s;
  endtask
  task automatic byte_in(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] blk, input logic rd);
    return {4'b1010, A2, blk, rd};
  endfunction

  task automatic write_seq(input logic [9:0] a, input int n, output logic all_ack);
    logic k;
    logic [9:0] slot;
    start_c();
    byte_out(dev(a[9:8], 1'b0), k); all_ack = k;
    byte_out(a[7:0], k); all_ack &= k;
    for (int i = 0; i < n; i++) begin
      byte_out(wbuf[i], k); all_ack &= k;
      slot = {a[9:4], 4'(a[3:0] + 4'(i))};
      if (!(wp && slot[9])) model[slot] = wbuf[i];
    end
    stop_c();
  endtask
  task automatic wait_wr(); repeat (WR + 40) @(negedge clk); endtask
  task automatic rand_read(input logic [9:0] a, input int n);
    logic k;
    start_c();
    byte_out(dev(a[9:8], 1'b0), k);
    byte_out(a[7:0], k);
    start_c();
    byte_out(dev(2'b00, 1'b1), k);
    for (int i = 0; i < n; i++) byte_in(i != n - 1, rbuf[i]);
    stop_c();
  endtask
  task automatic probe(output logic k);
    start_c(); byte_out(dev(2'b00, 1'b0), k); stop_c();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [9:0] a;
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 idle release", {7'd0, sda_oe}, 8'h00);

    // table walk: byte writes, some under write-protect, each read back
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][18:9];
      wp = VEC[v][0];
      wbuf[0] = VEC[v][8:1];
      write_seq(a, 1, ok);
      chk("R12 R3 acks", {7'd0, ok}, 8'h01);
      wait_wr();
      rand_read(a, 1);
      chk(VEC[v][0] ? "R7 protect" : "R3 R2 byte", rbuf[0], model[a]);
    end
    wp = 1'b0;

    // R4: page write wrapping inside the page
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h20 + 8'(i);
    write_seq(10'h0FC, 6, ok); wait_wr();
    rand_read(10'h0F0, 2);
    for (int i = 0; i < 2; i++) chk("R4 R8 wrap", rbuf[i], model[10'h0F0 + 10'(i)]);
    rand_read(10'h0FC, 4);
    for (int i = 0; i < 4; i++) chk("R4 R8 head", rbuf[i], model[10'h0FC + 10'(i)]);

    // R4: more than sixteen bytes overwrite the first slots
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h80 + 8'(i);
    write_seq(10'h040, 18, ok); wait_wr();
    rand_read(10'h040, 3);
    chk("R4 over0", rbuf[0], 8'h90);
    chk("R4 over1", rbuf[1], 8'h91);
    chk("R4 over2", rbuf[2], 8'h82);

    // R7: page write into the protected half
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    write_seq(10'h300, 2, ok); wait_wr();
    wp = 1'b1; wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    write_seq(10'h300, 2, ok); wait_wr();
    chk("R7 acked", {7'd0, ok}, 8'h01);
    wp = 1'b0;
    rand_read(10'h300, 2);
    chk("R7 kept0", rbuf[0], 8'hC1);
    chk("R7 kept1", rbuf[1], 8'hC2);

    // R9: sequential read across the end of the array, R10 current address
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1;
    write_seq(10'h3FE, 2, ok); wait_wr();
    wbuf[0] = 8'hF0; wbuf[1] = 8'hF1; wbuf[2] = 8'hF2;
    write_seq(10'h000, 3, ok); wait_wr();
    rand_read(10'h3FE, 4);
    chk("R9 seq0", rbuf[0], 8'hE0);
    chk("R9 seq1", rbuf[1], 8'hE1);
    chk("R9 seq2", rbuf[2], 8'hF0);
    chk("R9 seq3", rbuf[3], 8'hF1);
    chk("R13 released", {7'd0, sda_oe}, 8'h00);
    start_c(); byte_out(dev(2'b00, 1'b1), k); byte_in(1'b0, rbuf[0]); stop_c();
    chk("R10 current", rbuf[0], 8'hF2);

    // R5: a repeated start before the stop discards the data byte
    start_c();
    byte_out(dev(2'b00, 1'b0), k); byte_out(8'h05, k); byte_out(8'h5A, k);
    start_c(); stop_c();
    probe(k);
    chk("R5 no window", {7'd0, k}, 8'h01);
    rand_read(10'h005, 1);
    chk("R5 unchanged", rbuf[0], 8'hA5);

    // R1: address mismatch on strap and on type code
    start_c(); byte_out({4'b1010, ~A2, 3'b000}, k); stop_c();
    chk("R1 strap", {7'd0, k}, 8'h00);
    start_c(); byte_out({4'b1011, A2, 3'b000}, k); stop_c();
    chk("R1 type", {7'd0, k}, 8'h00);

    // R6: poll inside the busy window, then after it
    wbuf[0] = 8'h77;
    write_seq(10'h010, 1, ok);
    probe(k);
    chk("R6 busy nack", {7'd0, k}, 8'h00);
    wait_wr();
    probe(k);
    chk("R6 ack after", {7'd0, k}, 8'h01);
    rand_read(10'h010, 1);
    chk("R3 after window", rbuf[0], 8'h77);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule